// File: doc/BRIEF.md
# Sync-Referenced Oscillator Trim Controller

This block measures how far a fast oscillator drifts from its target frequency, using a slow reference pulse as the time base. The fast oscillator also clocks the block. A 16-bit counter is loaded with a programmable reload value and counts down once per clock. When it reaches zero the next reference pulse is due. If no pulse has arrived by then, the counter turns round and counts up. Each reference pulse captures the counter and its direction, which together give the size and sign of the frequency error. The pulse then reloads the counter.

Each captured error is graded against a programmable limit into one of four outcomes: in tolerance, warning, error, or a missing reference pulse. The outcome is kept in sticky status flags, which drive a shared interrupt line through per-flag enables. When automatic trimming is on, a warning moves a 6-bit trim output by one step and an error moves it by two, always toward a smaller error. The trim value saturates at both ends of its range and flags any step it could not take in full.

Software talks to the block over a simple write port with three targets: a control word, a configuration word and a flag-clear word. The configuration and the trim value can be read back on dedicated outputs. While the counter runs, the configuration is frozen. While automatic trimming is on, software cannot change the trim value.

Top module: `freq_trim_unit`

## Requirements
- R1: After reset the reload value is 0xBB7F, the limit is 0x22, the trim value is 32, all status flags, the capture value and the interrupt are 0, and the counter is stopped.
- R2: While running, the counter counts down from the reload value by one per clock. It raises the expected-pulse flag (status bit 2) in the cycle it holds zero, then counts up. A reference pulse spaced exactly reload+1 cycles after the previous one therefore captures zero.
- R3: Each accepted reference pulse captures the counter value. It also records the direction: 1 if the counter was still counting down (the oscillator is slow), 0 if it was counting up (the oscillator is fast). The counter then reloads.
- R4: A captured error below the limit sets the in-tolerance flag (status bit 0). An error of at least the limit but below 3 times the limit sets the warning flag (status bit 1). An error of 3 times the limit or more sets the sync-error flag (status bit 3).
- R5: If the up-count reaches 4 times the limit with no pulse, the missed flag (status bit 4) is set and the counter stops. The next pulse only restarts the counter from the reload value: it does not capture, grade or trim.
- R6: With automatic trimming on (control bit 1), a warning steps the trim value by 1 and a sync-error steps it by 2. A slow result steps it up and a fast result steps it down. The in-tolerance outcome leaves the trim value unchanged.
- R7: A trim step that would pass 63 or go below 0 clamps the value at that end and sets the trim-overflow flag (status bit 5).
- R8: A configuration write (select 1; reload in data bits 15:0, limit in bits 23:16) has no effect while the run bit (control bit 0) is set. A control write (select 0) replaces the trim value from data bits 12:7 only while automatic trimming is off.
- R9: A clear write (select 2) clears in-tolerance with bit 0, warning with bit 1, expected-pulse with bit 3, and with bit 2 clears sync-error, missed and trim-overflow together. The err_any output is the OR of those three flags.
- R10: The interrupt is the OR of the in-tolerance, warning, err_any and expected-pulse flags, each gated by its enable in control bits 2, 3, 4 and 5.
- R11: Reference pulses are ignored while the run bit is clear. A control write with bit 6 set acts as a reference pulse when the run bit was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Conditioned reference pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 configuration, 2 clear |
| wr_data | input | 24 | Write data |
| trim_out | output | 6 | Oscillator trim value |
| cap_count | output | 16 | Counter value captured at the last graded pulse |
| cap_slow | output | 1 | Direction at capture: 1 slow, 0 fast |
| status | output | 6 | Sticky flags: in-tolerance, warning, expected-pulse, sync-error, missed, trim-overflow (bits 0 to 5) |
| err_any | output | 1 | OR of sync-error, missed and trim-overflow |
| irq | output | 1 | Gated interrupt request |
| reload_out | output | 16 | Current reload value |
| limit_out | output | 8 | Current error limit |

## Verification
The bench uses a reload of 20 and a limit of 4, then sends reference pulses at spacings of 5, 15, 21, 24, 26 and 35 cycles. The exact spacing of 21 gives a zero error. The other spacings separate slow from fast and fall into each grading band. Spacing 24 lands just below the warning threshold, 26 lands just above it, and 35 lands past three times the limit. Trim runs start from 62 and from 1, so each end of the range is reached with a step that cannot be taken in full. A long gap with no pulse shows the counter stopping and the next pulse restarting it without a capture. The last pulse is issued as a software write, which shows it is timed the same as a pin pulse.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NONE = 2'd3
  } ftc_sel_e;

  // control word bit positions
  localparam int C_RUN      = 0;
  localparam int C_AUTO     = 1;
  localparam int C_IE_LSB   = 2;
  localparam int C_SWSYNC   = 6;
  localparam int C_TRIM_LSB = 7;
  localparam int CTRL_W     = 6;

  // clear word / interrupt enable bit positions
  localparam int K_OK   = 0;
  localparam int K_WARN = 1;
  localparam int K_ERR  = 2;
  localparam int K_EXP  = 3;

  // status vector bit positions
  localparam int F_OK   = 0;
  localparam int F_WARN = 1;
  localparam int F_EXP  = 2;
  localparam int F_SERR = 3;
  localparam int F_MISS = 4;
  localparam int F_TOVF = 5;
  localparam int F_N    = 6;
endpackage

// File: rtl/ftc_regs.sv
module ftc_regs
  import ftc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8,
  parameter logic [CNT_W-1:0] RELOAD_RST = 'hBB7F,
  parameter logic [LIM_W-1:0] LIMIT_RST  = 'h22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [CNT_W+LIM_W-1:0] wr_data,
  input  logic [F_N-1:0]         flag_set,
  output logic                   run_en,
  output logic                   auto_en,
  output logic                   sw_sync,
  output logic                   ctrl_wr,
  output logic [CNT_W-1:0]       reload,
  output logic [LIM_W-1:0]       limit,
  output logic [F_N-1:0]         flags,
  output logic                   err_any,
  output logic                   irq
);
  ftc_sel_e sel;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [LIM_W-1:0]  limit_q, limit_d;
  logic [F_N-1:0]    flags_q, flags_d, clr;
  logic              cfg_wr, clr_wr;
  logic [3:0]        ie;

  assign sel = ftc_sel_e'(wr_sel);

  always_comb begin
    ctrl_wr = wr_en && (sel == SEL_CTRL);
    cfg_wr  = wr_en && (sel == SEL_CFG) && !ctrl_q[C_RUN];
    clr_wr  = wr_en && (sel == SEL_CLR);
    ctrl_d  = ctrl_wr ? wr_data[CTRL_W-1:0] : ctrl_q;
    reload_d = cfg_wr ? wr_data[CNT_W-1:0] : reload_q;
    limit_d  = cfg_wr ? wr_data[CNT_W +: LIM_W] : limit_q;
    clr = '0;
    if (clr_wr) begin
      clr[F_OK]   = wr_data[K_OK];
      clr[F_WARN] = wr_data[K_WARN];
      clr[F_EXP]  = wr_data[K_EXP];
      clr[F_SERR] = wr_data[K_ERR];
      clr[F_MISS] = wr_data[K_ERR];
      clr[F_TOVF] = wr_data[K_ERR];
    end
    // a new event wins over a clear in the same cycle
    flags_d = (flags_q & ~clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= RELOAD_RST;
      limit_q  <= LIMIT_RST;
      flags_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      limit_q  <= limit_d;
      flags_q  <= flags_d;
    end
  end

  assign run_en  = ctrl_q[C_RUN];
  assign auto_en = ctrl_q[C_AUTO];
  assign sw_sync = ctrl_wr && wr_data[C_SWSYNC] && ctrl_q[C_RUN];
  assign ie      = ctrl_q[C_IE_LSB +: 4];
  assign reload  = reload_q;
  assign limit   = limit_q;
  assign flags   = flags_q;
  assign err_any = flags_q[F_SERR] | flags_q[F_MISS] | flags_q[F_TOVF];
  assign irq     = (ie[K_OK] & flags_q[F_OK]) | (ie[K_WARN] & flags_q[F_WARN]) |
                   (ie[K_ERR] & err_any) | (ie[K_EXP] & flags_q[F_EXP]);

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_RUN] |=> ($stable(reload_q) && $stable(limit_q))); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wr_data[K_ERR] && !flag_set[F_SERR] && !flag_set[F_MISS] && !flag_set[F_TOVF])
    |=> !err_any); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |-> !irq); // R10
endmodule

// File: rtl/ftc_counter.sv
module ftc_counter #(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_evt,
  input  logic [CNT_W-1:0] reload,
  input  logic [LIM_W-1:0] limit,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_slow,
  output logic             g_ok,
  output logic             g_warn,
  output logic             g_err,
  output logic             g_slow,
  output logic             exp_set,
  output logic             miss_set
);
  localparam int XW = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic             up_q, up_d, halt_q, halt_d, slow_q, slow_d;
  logic             graded;
  logic [XW-1:0]    lim1, lim3, lim4, cntx;

  assign lim1 = XW'(limit);
  assign lim3 = lim1 + (lim1 << 1);
  assign lim4 = lim1 << 2;
  assign cntx = XW'(cnt_q);

  always_comb begin
    cnt_d = cnt_q; up_d = up_q; halt_d = halt_q;
    cap_d = cap_q; slow_d = slow_q;
    graded = 1'b0; miss_set = 1'b0;
    if (!run) begin
      cnt_d = reload; up_d = 1'b0; halt_d = 1'b0;
    end else if (sync_evt) begin
      cnt_d = reload; up_d = 1'b0; halt_d = 1'b0;
      if (!halt_q) begin
        cap_d  = cnt_q;
        slow_d = !up_q;
        graded = 1'b1;
      end
    end else if (halt_q) begin
      cnt_d = cnt_q;
    end else if (!up_q) begin
      if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = CNT_W'(1);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end else if (cntx >= lim4) begin
      halt_d   = 1'b1;
      miss_set = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    g_ok   = graded && (cntx < lim1);
    g_warn = graded && (cntx >= lim1) && (cntx < lim3);
    g_err  = graded && (cntx >= lim3);
    g_slow = !up_q;
    exp_set = run && !halt_q && !up_q && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b0;
      halt_q <= 1'b0;
      cap_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      halt_q <= halt_d;
      cap_q  <= cap_d;
      slow_q <= slow_d;
    end
  end

  assign cap_val  = cap_q;
  assign cap_slow = slow_q;

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halt_q && !sync_evt) |=> $stable(cnt_q)); // R5
  AST_GRADE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_ok, g_warn, g_err})); // R4
  AST_MISS_NOGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && sync_evt) |=> $stable(cap_q)); // R5
endmodule

// File: rtl/ftc_trim.sv
module ftc_trim #(
  parameter int TRIM_W = 6,
  parameter logic [TRIM_W-1:0] TRIM_RST = 'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              wr_trim,
  input  logic [TRIM_W-1:0] wr_val,
  input  logic              g_warn,
  input  logic              g_err,
  input  logic              g_slow,
  output logic [TRIM_W-1:0] trim,
  output logic              ovf_set
);
  localparam int XW = TRIM_W + 1;
  localparam logic [XW-1:0] TOP = XW'((1 << TRIM_W) - 1);

  logic [TRIM_W-1:0] trim_q, trim_d;
  logic [XW-1:0]     step, base, sum;

  assign step = g_err ? XW'(2) : XW'(1);
  assign base = XW'(trim_q);
  assign sum  = base + step;

  always_comb begin
    trim_d  = trim_q;
    ovf_set = 1'b0;
    if (!auto_en) begin
      if (wr_trim) trim_d = wr_val;
    end else if (g_warn || g_err) begin
      if (g_slow) begin
        if (sum > TOP) begin
          trim_d = TOP[TRIM_W-1:0]; ovf_set = 1'b1;
        end else begin
          trim_d = sum[TRIM_W-1:0];
        end
      end else if (base < step) begin
        trim_d = '0; ovf_set = 1'b1;
      end else begin
        trim_d = trim_q - step[TRIM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trim_q <= TRIM_RST;
    else        trim_q <= trim_d;
  end

  assign trim = trim_q;

  AST_TRIM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !g_warn && !g_err) |=> $stable(trim_q)); // R6
  AST_TRIM_OVF_END: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ((trim_q == '0) || (XW'(trim_q) == TOP))); // R7
endmodule

// File: rtl/freq_trim_unit.sv
module freq_trim_unit
  import ftc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LIM_W  = 8,
  parameter int TRIM_W = 6,
  parameter logic [CNT_W-1:0]  RELOAD_RST = 'hBB7F,
  parameter logic [LIM_W-1:0]  LIMIT_RST  = 'h22,
  parameter logic [TRIM_W-1:0] TRIM_RST   = 'd32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_in,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [CNT_W+LIM_W-1:0] wr_data,
  output logic [TRIM_W-1:0]      trim_out,
  output logic [CNT_W-1:0]       cap_count,
  output logic                   cap_slow,
  output logic [F_N-1:0]         status,
  output logic                   err_any,
  output logic                   irq,
  output logic [CNT_W-1:0]       reload_out,
  output logic [LIM_W-1:0]       limit_out
);
  logic run_en, auto_en, sw_sync, ctrl_wr, sync_evt;
  logic g_ok, g_warn, g_err, g_slow, exp_set, miss_set, ovf_set;
  logic [F_N-1:0] flag_set;

  assign sync_evt = (run_en && sync_in) || sw_sync;

  always_comb begin
    flag_set = '0;
    flag_set[F_OK]   = g_ok;
    flag_set[F_WARN] = g_warn;
    flag_set[F_EXP]  = exp_set;
    flag_set[F_SERR] = g_err;
    flag_set[F_MISS] = miss_set;
    flag_set[F_TOVF] = ovf_set;
  end

  ftc_regs #(.CNT_W(CNT_W), .LIM_W(LIM_W), .RELOAD_RST(RELOAD_RST), .LIMIT_RST(LIMIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_set(flag_set), .run_en(run_en), .auto_en(auto_en), .sw_sync(sw_sync),
    .ctrl_wr(ctrl_wr), .reload(reload_out), .limit(limit_out), .flags(status),
    .err_any(err_any), .irq(irq));

  ftc_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en), .sync_evt(sync_evt),
    .reload(reload_out), .limit(limit_out), .cap_val(cap_count), .cap_slow(cap_slow),
    .g_ok(g_ok), .g_warn(g_warn), .g_err(g_err), .g_slow(g_slow),
    .exp_set(exp_set), .miss_set(miss_set));

  ftc_trim #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_trim (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .wr_trim(ctrl_wr),
    .wr_val(wr_data[C_TRIM_LSB +: TRIM_W]), .g_warn(g_warn), .g_err(g_err),
    .g_slow(g_slow), .trim(trim_out), .ovf_set(ovf_set));
endmodule

// File: tb/sim_freq_trim_unit.sv
module sim_freq_trim_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, sync_in, wr_en;
  logic [1:0]  wr_sel;
  logic [23:0] wr_data;
  logic [5:0]  trim_out;
  logic [15:0] cap_count, reload_out;
  logic        cap_slow, err_any, irq;
  logic [5:0]  status;
  logic [7:0]  limit_out;

  int n_chk = 0, n_bad = 0, since = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  freq_trim_unit u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .trim_out(trim_out), .cap_count(cap_count), .cap_slow(cap_slow),
    .status(status), .err_any(err_any), .irq(irq), .reload_out(reload_out),
    .limit_out(limit_out));

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [23:0] ctrlw(input bit en, input bit at, input logic [3:0] ie,
                                        input bit sw, input int trim);
    return 24'((trim & 63) << 7) | 24'({sw, ie, at, en});
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [23:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    since++;
  endtask

  // pulse seen d clock edges after the previous pulse edge
  task automatic sync_after(input int d);
    repeat (d - 1 - since) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    since = 0;
  endtask

  task automatic grade(input int d, input int st, input int cap, input int slow,
                       input int trim, input string req);
    sync_after(d);
    chk(req, "status", status, st);
    chk("R3", "capture", cap_count, cap);
    chk("R3", "direction", cap_slow, slow);
    chk(req, "trim", trim_out, trim);
  endtask

  task automatic t_reset();
    chk("R1", "trim", trim_out, 32);
    chk("R1", "reload", reload_out, 'hBB7F);
    chk("R1", "limit", limit_out, 'h22);
    chk("R1", "status", status, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "capture", cap_count, 0);
  endtask

  task automatic t_disabled_sync();
    since = 0;
    sync_after(1);
    chk("R11", "status after pulse while stopped", status, 0);
    chk("R11", "capture after pulse while stopped", cap_count, 0);
  endtask

  task automatic t_setup();
    wr(2'd1, {8'd4, 16'd20});
    chk("R8", "reload written while stopped", reload_out, 20);
    chk("R8", "limit written while stopped", limit_out, 4);
    wr(2'd0, ctrlw(1, 0, 4'b0, 0, 32));
    since = 0;
    sync_after(1);
    wr(2'd2, 24'hF);
  endtask

  task automatic t_grading();
    grade(21, 6'b000101, 0, 1, 32, "R2");  wr(2'd2, 24'hF);
    grade(24, 6'b000101, 3, 0, 32, "R4");  wr(2'd2, 24'hF);
    grade(15, 6'b000010, 6, 1, 32, "R4");  wr(2'd2, 24'hF);
    grade(35, 6'b001100, 14, 0, 32, "R4"); wr(2'd2, 24'hF);
  endtask

  task automatic t_autotrim();
    wr(2'd0, ctrlw(1, 1, 4'b0, 0, 32));
    grade(26, 6'b000110, 5, 0, 31, "R6");  wr(2'd2, 24'hF);
    grade(15, 6'b000010, 6, 1, 32, "R6");  wr(2'd2, 24'hF);
    grade(35, 6'b001100, 14, 0, 30, "R6"); wr(2'd2, 24'hF);
    grade(5, 6'b001000, 16, 1, 32, "R6");  wr(2'd2, 24'hF);
  endtask

  task automatic t_lock();
    wr(2'd1, {8'd9, 16'd100});
    wr(2'd0, ctrlw(1, 1, 4'b0, 0, 5));
    chk("R8", "reload while running", reload_out, 20);
    chk("R8", "limit while running", limit_out, 4);
    chk("R8", "trim write under auto-trim", trim_out, 32);
    grade(21, 6'b000101, 0, 1, 32, "R8");  wr(2'd2, 24'hF);
  endtask

  task automatic t_saturate();
    wr(2'd0, ctrlw(1, 0, 4'b0, 0, 62));
    wr(2'd0, ctrlw(1, 1, 4'b0, 0, 62));
    chk("R8", "trim written with auto-trim off", trim_out, 62);
    grade(5, 6'b101000, 16, 1, 63, "R7");
    chk("R9", "err_any after overflow", err_any, 1);
    wr(2'd2, 24'hF);
    wr(2'd0, ctrlw(1, 0, 4'b0, 0, 1));
    wr(2'd0, ctrlw(1, 1, 4'b0, 0, 1));
    grade(35, 6'b101100, 14, 0, 0, "R7");
  endtask

  task automatic t_clear();
    wr(2'd2, 24'b1011);
    chk("R9", "status after clearing other bits", status, 6'b101000);
    chk("R9", "err_any kept", err_any, 1);
    wr(2'd2, 24'b0100);
    chk("R9", "status after error clear", status, 0);
    chk("R9", "err_any after error clear", err_any, 0);
  endtask

  task automatic t_irq();
    wr(2'd0, ctrlw(1, 1, 4'b0001, 0, 0));
    grade(21, 6'b000101, 0, 1, 0, "R10");
    chk("R10", "irq with enable", irq, 1);
    wr(2'd0, ctrlw(1, 1, 4'b0000, 0, 0));
    chk("R10", "irq without enable", irq, 0);
    chk("R10", "flag kept", status, 6'b000101);
    wr(2'd2, 24'hF);
  endtask

  task automatic t_miss();
    repeat (45) @(negedge clk);
    chk("R5", "status after missing pulse", status, 6'b010100);
    chk("R5", "err_any after missing pulse", err_any, 1);
    chk("R5", "capture kept", cap_count, 0);
    since = 0;
    sync_after(1);
    chk("R5", "status after restart pulse", status, 6'b010100);
    chk("R5", "capture after restart pulse", cap_count, 0);
    wr(2'd2, 24'hF);
    grade(21, 6'b000101, 0, 1, 0, "R5");
    wr(2'd2, 24'hF);
  endtask

  task automatic t_swsync();
    repeat (24 - 1 - since) @(negedge clk);
    wr(2'd0, ctrlw(1, 1, 4'b0, 1, 0));
    chk("R11", "status after software pulse", status, 6'b000101);
    chk("R11", "capture after software pulse", cap_count, 3);
    chk("R11", "direction after software pulse", cap_slow, 0);
  endtask

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_sync();
    t_setup();
    t_grading();
    t_autotrim();
    t_lock();
    t_saturate();
    t_clear();
    t_irq();
    t_miss();
    t_swsync();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule